// File: doc/BRIEF.md
# Stack Expansion Bus Port

This block is one device's connection to a shared 5-bit symbol bus that links several repeater devices in a stack. When the local repeater has traffic, the block raises a bus request toward an external arbiter. It then waits for the arbiter's active-low grant. The grant arrives asynchronously, so the block synchronises it and requires a minimum width before it accepts it. After acceptance, the block raises a data-activity flag, takes over the bus one clock later, and sends a forwarded clock along with the symbols.

The block also accepts two inputs from the stack: a carrier-sense line and a forced-jam line. Both are synchronised, and the jam line must also hold for a minimum width. A qualified jam tells every local port to send jam. The block's own jam-out is the registered OR of the per-port jam requests and the internal collision. The incoming jam line never feeds jam-out.

When a collision ends, the block masks grants until the local request has dropped once. A device that has just collided therefore cannot take the bus again in the same burst of activity.

Top module: `xbus_port`

## Requirements
- R1: `bus_req` follows `local_act` combinationally, with no clock delay.
- R2: With `long_qual`=0, the grant must be seen low for 2 cycles after the two-flop synchroniser. Inputs change at a falling edge. `gnt_n` held low from one falling edge raises `data_act` after the 5th rising edge, as long as `local_act` stays high. A grant pulse that spans only 1 rising edge never raises `data_act`.
- R3: With `long_qual`=1, the grant must be seen low for 4 synchronised cycles. `data_act` rises after the 7th rising edge. A grant pulse that spans 2 rising edges is ignored.
- R4: `bus_oe` rises one rising edge after `data_act`. While `bus_oe` is high, `bus_dout` carries the `local_sym` value sampled at the previous rising edge.
- R5: When `bus_oe` is low, `bus_dout` is all zeros and `bus_clk_out` is low. When `bus_oe` is high, `bus_clk_out` is the inverted local clock, which puts its rising edge mid-symbol.
- R6: If `local_act` drops, `data_act` and `bus_oe` both go low at the next rising edge. If `gnt_n` returns high, both go low after the 4th rising edge.
- R7: `jam_all` rises after the 4th rising edge once `jam_in` is held high (2 synchroniser edges plus 2 qualification edges). It falls after the 3rd rising edge once `jam_in` drops. A 1-edge pulse on `jam_in` never raises `jam_all`.
- R8: `jam_out` is the OR of all `port_jam_req` bits and `int_coll`, registered by one rising edge. `jam_in` has no effect on `jam_out`.
- R9: When `int_coll` falls while `local_act` is high, `data_act` drops at the next rising edge. It stays low while the grant is still held, until `local_act` has gone low. After that, a new request with the grant still held raises `data_act` one edge later.
- R10: `carrier_seen` is `carrier_in` delayed by two rising edges.
- R11: While `rst` is high, `data_act`, `bus_oe`, `bus_dout`, `jam_all`, `jam_out` and `carrier_seen` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| local_act | input | 1 | Local repeater has data for the bus |
| local_sym | input | 5 | Symbol to place on the bus |
| long_qual | input | 1 | 1 selects the 4-cycle grant qualification, 0 selects 2 cycles |
| port_jam_req | input | 8 | Per-port carrier-integrity jam requests |
| int_coll | input | 1 | Internal collision indication |
| gnt_n | input | 1 | Asynchronous active-low bus grant from the arbiter |
| carrier_in | input | 1 | Asynchronous stack carrier sense |
| jam_in | input | 1 | Asynchronous stack forced-jam input |
| bus_req | output | 1 | Request for the shared bus |
| data_act | output | 1 | Grant accepted; the bus is driven from the next edge |
| bus_oe | output | 1 | Output enable for the 5-bit bus |
| bus_dout | output | 5 | Symbol driven onto the bus |
| bus_clk_out | output | 1 | Forwarded bus clock, gated by `bus_oe` |
| carrier_seen | output | 1 | Synchronised stack carrier sense |
| jam_all | output | 1 | Qualified jam command to all local ports |
| jam_out | output | 1 | Jam request to the stack |

## Verification
If a qualification counter held the wrong state, `data_act` or `jam_all` would rise one or more edges off from the cycle counts in R2, R3 and R7, or a short pulse would get through. A broken collision mask would let `data_act` come back while the grant is still held, within one edge of the collision ending. Drive-state errors show up one edge after `data_act` changes: `bus_oe`, `bus_dout` or the gated clock would be out of step.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    localparam int SYM_W = 5;

    // Synchronised view of the asynchronous stack inputs
    typedef struct packed {
        logic grant;    // active-high form of gnt_n
        logic carrier;
        logic jam;
    } xin_t;

    // State of the bus driver
    typedef struct packed {
        logic             act;
        logic             oe;
        logic [SYM_W-1:0] dat;
    } drv_t;

    function automatic int cnt_w(input int n);
        return $clog2(n + 1);
    endfunction
endpackage

// File: rtl/xbus_sync.sv
module xbus_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/xbus_qual.sv
module xbus_qual #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    input  logic [CW-1:0] need,
    output logic          q
);
    logic [CW-1:0] cnt;

    // Count consecutive high cycles and stop at the required length
    always_ff @(posedge clk) begin
        if (rst || !din) cnt <= '0;
        else if (cnt < need) cnt <= cnt + 1'b1;
    end

    assign q = (need != '0) && (cnt >= need);

    // R2/R7: a qualified level needs the input high on the previous cycle
    a_r2_min_width: assert property (@(posedge clk) disable iff (rst)
        q |-> $past(din));
endmodule

// File: rtl/xbus_port.sv
module xbus_port
    import xbus_pkg::*;
#(
    parameter int NPORT     = 8,
    parameter int GNT_SHORT = 2,
    parameter int GNT_LONG  = 4,
    parameter int JAM_LEN   = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             local_act,
    input  logic [SYM_W-1:0] local_sym,
    input  logic             long_qual,
    input  logic [NPORT-1:0] port_jam_req,
    input  logic             int_coll,
    input  logic             gnt_n,
    input  logic             carrier_in,
    input  logic             jam_in,
    output logic             bus_req,
    output logic             data_act,
    output logic             bus_oe,
    output logic [SYM_W-1:0] bus_dout,
    output logic             bus_clk_out,
    output logic             carrier_seen,
    output logic             jam_all,
    output logic             jam_out
);
    localparam int QMAX = (GNT_LONG > JAM_LEN) ? GNT_LONG : JAM_LEN;
    localparam int QW   = cnt_w(QMAX);

    xin_t raw, syn;
    logic [$bits(xin_t)-1:0] syn_v;

    assign raw = '{grant: ~gnt_n, carrier: carrier_in, jam: jam_in};

    xbus_sync #(.W($bits(xin_t))) u_sync (
        .clk(clk), .rst(rst), .d(raw), .q(syn_v)
    );
    assign syn = xin_t'(syn_v);

    logic [QW-1:0] gnt_need;
    logic          gnt_q;
    assign gnt_need = long_qual ? QW'(GNT_LONG) : QW'(GNT_SHORT);

    xbus_qual #(.CW(QW)) u_gnt_qual (
        .clk(clk), .rst(rst), .din(syn.grant), .need(gnt_need), .q(gnt_q)
    );

    xbus_qual #(.CW(QW)) u_jam_qual (
        .clk(clk), .rst(rst), .din(syn.jam), .need(QW'(JAM_LEN)), .q(jam_all)
    );

    // Post-collision mask: armed on the collision's falling edge while requesting
    logic coll_d, mask_q, coll_end, grant_ok;
    assign coll_end = coll_d && !int_coll;
    assign grant_ok = gnt_q && local_act && !mask_q && !coll_end;

    always_ff @(posedge clk) begin
        if (rst) begin
            coll_d <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            coll_d <= int_coll;
            if (!local_act)    mask_q <= 1'b0;
            else if (coll_end) mask_q <= 1'b1;
        end
    end

    // Driver: flag first, bus one edge later
    drv_t drv;
    always_ff @(posedge clk) begin
        if (rst) begin
            drv <= '0;
        end else begin
            drv.act <= grant_ok;
            drv.oe  <= drv.act && grant_ok;
            drv.dat <= (drv.act && grant_ok) ? local_sym : '0;
        end
    end

    logic jam_r;
    always_ff @(posedge clk) begin
        if (rst) jam_r <= 1'b0;
        else     jam_r <= (|port_jam_req) || int_coll;
    end

    assign bus_req      = local_act;
    assign data_act     = drv.act;
    assign bus_oe       = drv.oe;
    assign bus_dout     = drv.dat;
    assign bus_clk_out  = drv.oe & ~clk;
    assign carrier_seen = syn.carrier;
    assign jam_out      = jam_r;

    a_r4_drive_after_flag: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(data_act));
    a_r5_quiet_bus: assert property (@(posedge clk) disable iff (rst)
        !bus_oe |-> (bus_dout == '0));
    a_r6_release: assert property (@(posedge clk) disable iff (rst)
        !local_act |=> (!data_act && !bus_oe));
    a_r8_jam_source: assert property (@(posedge clk) disable iff (rst)
        (!(|$past(port_jam_req)) && !$past(int_coll)) |-> !jam_out);
    a_r9_mask_holds: assert property (@(posedge clk) disable iff (rst)
        (mask_q && $past(mask_q)) |-> !data_act);
endmodule

// File: tb/xbus_port_tb.sv
module xbus_port_tb;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       local_act, long_qual, int_coll, gnt_n, carrier_in, jam_in;
    logic [4:0] local_sym;
    logic [7:0] port_jam_req;
    logic       bus_req, data_act, bus_oe, bus_clk_out, carrier_seen, jam_all, jam_out;
    logic [4:0] bus_dout;

    int total = 0;
    int bad   = 0;

    always #(CLK_P / 2) clk = ~clk;

    xbus_port u_dut (
        .clk(clk), .rst(rst), .local_act(local_act), .local_sym(local_sym),
        .long_qual(long_qual), .port_jam_req(port_jam_req), .int_coll(int_coll),
        .gnt_n(gnt_n), .carrier_in(carrier_in), .jam_in(jam_in),
        .bus_req(bus_req), .data_act(data_act), .bus_oe(bus_oe),
        .bus_dout(bus_dout), .bus_clk_out(bus_clk_out),
        .carrier_seen(carrier_seen), .jam_all(jam_all), .jam_out(jam_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One rising edge, then settle on the falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; local_act = 0; long_qual = 0; int_coll = 0; gnt_n = 1;
        carrier_in = 0; jam_in = 0; local_sym = 5'h15; port_jam_req = '0;
        repeat (3) tick();
        chk("R11 data_act", {7'd0, data_act}, 8'd0);
        chk("R11 bus_oe", {7'd0, bus_oe}, 8'd0);
        chk("R11 bus_dout", {3'd0, bus_dout}, 8'd0);
        chk("R11 jam", {6'd0, jam_all, jam_out}, 8'd0);
        chk("R11 carrier", {7'd0, carrier_seen}, 8'd0);
        rst = 1'b0;
        tick();
    endtask

    task automatic t_req();
        local_act = 1; #1;
        chk("R1 req high", {7'd0, bus_req}, 8'd1);
        local_act = 0; #1;
        chk("R1 req low", {7'd0, bus_req}, 8'd0);
        tick();
    endtask

    // Grant held low: flag after n+3 edges, bus one edge later, then release
    task automatic t_grant(input int n, input string rq);
        local_act = 1; long_qual = (n > 2); local_sym = 5'h15; gnt_n = 0;
        for (int k = 1; k <= n + 3; k++) begin
            tick();
            if (k == n + 2) chk({rq, " flag early"}, {7'd0, data_act}, 8'd0);
        end
        chk({rq, " flag on time"}, {7'd0, data_act}, 8'd1);
        chk("R4 oe lags flag", {7'd0, bus_oe}, 8'd0);
        tick();
        chk("R4 oe up", {7'd0, bus_oe}, 8'd1);
        chk("R4 data", {3'd0, bus_dout}, 8'h15);
        chk("R5 clk fwd", {7'd0, bus_clk_out}, 8'd1);
        local_sym = 5'h0A;
        tick();
        chk("R4 data next", {3'd0, bus_dout}, 8'h0A);
        local_act = 0;
        tick();
        chk("R6 req drop", {6'd0, data_act, bus_oe}, 8'd0);
        chk("R5 idle bus", {3'd0, bus_dout}, 8'd0);
        chk("R5 idle clk", {7'd0, bus_clk_out}, 8'd0);
        gnt_n = 1;
        repeat (5) tick();
    endtask

    task automatic t_pulse(input int width, input logic lq, input string rq);
        int seen = 0;
        local_act = 1; long_qual = lq; gnt_n = 0;
        for (int k = 0; k < width; k++) begin
            tick();
            seen |= data_act;
        end
        gnt_n = 1;
        for (int k = 0; k < 8; k++) begin
            tick();
            seen |= data_act;
        end
        chk({rq, " short grant ignored"}, 8'(seen), 8'd0);
        local_act = 0;
        tick();
    endtask

    task automatic t_gnt_drop();
        local_act = 1; long_qual = 0; gnt_n = 0;
        repeat (6) tick();
        gnt_n = 1;
        repeat (3) tick();
        chk("R6 flag holds 3", {7'd0, data_act}, 8'd1);
        tick();
        chk("R6 grant drop", {6'd0, data_act, bus_oe}, 8'd0);
        local_act = 0;
        repeat (2) tick();
    endtask

    task automatic t_mask();
        local_act = 1; long_qual = 0; gnt_n = 0;
        repeat (6) tick();
        chk("R9 granted", {7'd0, data_act}, 8'd1);
        int_coll = 1;
        tick();
        chk("R8 coll jam", {7'd0, jam_out}, 8'd1);
        int_coll = 0;
        tick();
        chk("R9 masked", {7'd0, data_act}, 8'd0);
        repeat (4) tick();
        chk("R9 still masked", {6'd0, data_act, bus_oe}, 8'd0);
        local_act = 0;
        tick();
        local_act = 1;
        tick();
        chk("R9 unmasked", {7'd0, data_act}, 8'd1);
        local_act = 0; gnt_n = 1;
        repeat (5) tick();
    endtask

    task automatic t_jam();
        int seen = 0;
        jam_in = 1;
        repeat (3) tick();
        chk("R7 jam early", {7'd0, jam_all}, 8'd0);
        tick();
        chk("R7 jam on", {7'd0, jam_all}, 8'd1);
        chk("R8 jam_in no jam_out", {7'd0, jam_out}, 8'd0);
        jam_in = 0;
        repeat (2) tick();
        chk("R7 jam hold", {7'd0, jam_all}, 8'd1);
        tick();
        chk("R7 jam off", {7'd0, jam_all}, 8'd0);
        jam_in = 1;
        tick();
        jam_in = 0;
        for (int k = 0; k < 6; k++) begin
            tick();
            seen |= jam_all;
        end
        chk("R7 jam pulse ignored", 8'(seen), 8'd0);
    endtask

    task automatic t_portjam();
        port_jam_req = 8'h40; #1;
        chk("R8 not yet", {7'd0, jam_out}, 8'd0);
        tick();
        chk("R8 port jam", {7'd0, jam_out}, 8'd1);
        port_jam_req = '0;
        tick();
        chk("R8 port jam clear", {7'd0, jam_out}, 8'd0);
    endtask

    task automatic t_carrier();
        carrier_in = 1;
        tick();
        chk("R10 carrier 1 edge", {7'd0, carrier_seen}, 8'd0);
        tick();
        chk("R10 carrier 2 edges", {7'd0, carrier_seen}, 8'd1);
        carrier_in = 0;
        repeat (2) tick();
        chk("R10 carrier off", {7'd0, carrier_seen}, 8'd0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_req();
        t_grant(2, "R2");
        t_grant(4, "R3");
        t_pulse(1, 1'b0, "R2");
        t_pulse(2, 1'b1, "R3");
        t_gnt_drop();
        t_mask();
        t_jam();
        t_portjam();
        t_carrier();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_P * 100000);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule